// File: doc/BRIEF.md
# Key-Locked Watchdog Timer

This block is a watchdog. A 16-bit down-counter is advanced by a programmable prescaler. If software stops servicing it, the counter runs out and the block drives a 16-cycle active-low reset pulse. After the pulse, the counter reloads and runs again.

Each of the four configuration registers has its own guard register: kick, start value, enable and prescale. A guard opens only after it receives two specific keys in order. It then lets exactly one write through to its companion register and closes again. Software must first program both the start value and the prescale through their guards, and then write 1 to the enable register through its guard. Once the watchdog runs, no write can stop it. Only the synchronous system reset clears it.

Software talks to the block through a simple single-cycle write bus with a combinational read path. It services the watchdog by opening the kick guard and writing the kick code.

Top module: `wdog_keylock_top`

## Requirements
- R1: A guard moves from closed (state 0) to first-key (state 1) on a write of 0x5555, and from first-key to open (state 2) on a write of 0xAAAA. Reading a guard address returns its state in bits [1:0].
- R2: On any other guard write, the guard goes to closed, except that 0x5555 always moves it to first-key. This includes 0xAAAA while the guard is closed.
- R3: A write to a protected register is ignored while its guard is not open.
- R4: One write to a protected register while its guard is open is applied, and the guard returns to closed in the same cycle.
- R5: An enable write with bit 0 set starts the watchdog only if the start value and prescale have each been accepted at least once. Otherwise that write has no effect. Bit 0 of the enable register reads 1 while running.
- R6: Once running, the watchdog cannot be stopped by any bus write, including an accepted enable write of 0. Only the reset input clears it.
- R7: After a load of start value S with prescale P, the reset output falls exactly (S+1)·(P+1) clock edges later. While the watchdog is not running, the output stays high.
- R8: The reset output stays low for exactly 16 cycles. On the edge where it returns high, the counter holds the current start value, and the next expiry follows the same (S+1)·(P+1) rule.
- R9: An accepted kick write of 0xC0DE while running reloads the counter and the prescaler from the start value, which restarts the R7 interval. Any other accepted kick value has no effect on the counter but still closes the guard.
- R10: After reset, all guards are closed, the start value is 0xFFFF, the prescale is 0, the watchdog is stopped, the count reads 0 and the reset output is high.
- R11: The register map has eight 16-bit registers at byte offsets 0x0 to 0xE, each guard at an even-word offset directly below its register: kick guard 0x0, kick 0x2 (reads the current count), start guard 0x4, start 0x6, enable guard 0x8, enable 0xA, prescale guard 0xC, prescale 0xE. A write with address bit 0 set is ignored entirely.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| wdt_rst_n | output | 1 | Active-low expiry reset pulse |

## Verification
The assertions assume one register access per cycle. They also assume the reset input is held for at least one edge before any bus activity, so that the history seen through $past begins in the closed, stopped state.

The stimulus issues each write as a single-cycle strobe driven on the falling clock edge. Random key and data writes go only to the start-value and prescale pairs and to odd addresses before the watchdog is enabled. No random write can therefore start the watchdog and disturb the timing checks that follow.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
    localparam int DW = 16;
    localparam int AW = 4;
    localparam int NREG = 4;

    localparam logic [DW-1:0] KEY_FIRST  = 16'h5555;
    localparam logic [DW-1:0] KEY_SECOND = 16'hAAAA;
    localparam logic [DW-1:0] KICK_CODE  = 16'hC0DE;

    typedef enum logic [1:0] {
        LK_CLOSED = 2'd0,
        LK_KEY1   = 2'd1,
        LK_OPEN   = 2'd2
    } lock_st_e;

    typedef enum logic [1:0] {
        SEL_KICK  = 2'd0,
        SEL_START = 2'd1,
        SEL_EN    = 2'd2,
        SEL_PRESC = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic           is_data;
        reg_sel_e       sel;
        logic           valid;
    } bus_dec_t;

    function automatic lock_st_e lock_next(lock_st_e cur, logic [DW-1:0] v);
        if (v == KEY_FIRST)
            return LK_KEY1;
        else if (v == KEY_SECOND && cur == LK_KEY1)
            return LK_OPEN;
        else
            return LK_CLOSED;
    endfunction

    function automatic bus_dec_t bus_decode(logic [AW-1:0] a);
        bus_dec_t d;
        d.valid   = ~a[0];
        d.is_data = a[1];
        d.sel     = reg_sel_e'(a[3:2]);
        return d;
    endfunction
endpackage

// File: rtl/wdk_lock.sv
module wdk_lock
    import wdk_pkg::*;
#(
    parameter int W = DW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         key_we,
    input  logic         data_we,
    input  logic [W-1:0] wdata,
    output logic         open_o,
    output lock_st_e     state_o
);
    lock_st_e st_q;

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= LK_CLOSED;
        else if (key_we)
            st_q <= lock_next(st_q, wdata);
        else if (data_we && st_q == LK_OPEN)
            st_q <= LK_CLOSED;
    end

    assign open_o  = (st_q == LK_OPEN);
    assign state_o = st_q;

    // R1: the open state is entered only from the first-key state
    assert_open_via_key1_R1: assert property (@(posedge clk) disable iff (rst)
        (st_q == LK_OPEN && $past(st_q) != LK_OPEN) |-> $past(st_q) == LK_KEY1);

    // R4: a data write through an open guard closes it
    assert_relock_after_use_R4: assert property (@(posedge clk) disable iff (rst)
        (data_we && !key_we && st_q == LK_OPEN) |=> st_q == LK_CLOSED);
endmodule

// File: rtl/wdk_core.sv
module wdk_core #(
    parameter int W         = 16,
    parameter int PULSE_LEN = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en_i,
    input  logic         load_i,
    input  logic         kick_i,
    input  logic [W-1:0] start_i,
    input  logic [W-1:0] presc_i,
    output logic [W-1:0] count_o,
    output logic         rst_n_o
);
    localparam int PW = $clog2(PULSE_LEN + 1);

    logic [W-1:0]  pre_q;
    logic [W-1:0]  cnt_q;
    logic [PW-1:0] pulse_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q   <= '0;
            cnt_q   <= '0;
            pulse_q <= '0;
        end else if (load_i) begin
            pre_q <= '0;
            cnt_q <= start_i;
        end else if (en_i) begin
            if (pulse_q != '0) begin
                pulse_q <= pulse_q - PW'(1);
                if (pulse_q == PW'(1)) begin
                    pre_q <= '0;
                    cnt_q <= start_i;
                end
            end else if (kick_i) begin
                pre_q <= '0;
                cnt_q <= start_i;
            end else if (pre_q == presc_i) begin
                pre_q <= '0;
                if (cnt_q == '0)
                    pulse_q <= PW'(PULSE_LEN);
                else
                    cnt_q <= cnt_q - W'(1);
            end else begin
                pre_q <= pre_q + W'(1);
            end
        end
    end

    assign count_o = cnt_q;
    assign rst_n_o = (pulse_q == '0);

    // R7: no reset pulse while stopped
    assert_quiet_when_stopped_R7: assert property (@(posedge clk) disable iff (rst)
        !en_i |-> rst_n_o);

    // R8: the pulse lasts more than one cycle
    assert_pulse_not_glitch_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(rst_n_o) |=> !rst_n_o);

    // R8: the counter is reloaded when the pulse ends
    assert_reload_after_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_n_o) |-> cnt_q == $past(start_i));
endmodule

// File: rtl/wdog_keylock_top.sv
module wdog_keylock_top
    import wdk_pkg::*;
#(
    parameter int PULSE_LEN = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          wdt_rst_n
);
    bus_dec_t       dec;
    logic [NREG-1:0] key_we;
    logic [NREG-1:0] data_we;
    logic [NREG-1:0] guard_open;
    lock_st_e        guard_st [NREG];
    logic [NREG-1:0] accept;

    logic [DW-1:0] start_q, presc_q, count;
    logic          start_set_q, presc_set_q, en_q;
    logic          en_set, kick;

    assign dec = bus_decode(bus_addr);

    for (genvar g = 0; g < NREG; g++) begin : g_guard
        assign key_we[g]  = bus_we && dec.valid && !dec.is_data && dec.sel == reg_sel_e'(g);
        assign data_we[g] = bus_we && dec.valid &&  dec.is_data && dec.sel == reg_sel_e'(g);
        assign accept[g]  = data_we[g] && guard_open[g];

        wdk_lock #(.W(DW)) u_lock (
            .clk     (clk),
            .rst     (rst),
            .key_we  (key_we[g]),
            .data_we (data_we[g]),
            .wdata   (bus_wdata),
            .open_o  (guard_open[g]),
            .state_o (guard_st[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q     <= '1;
            presc_q     <= '0;
            start_set_q <= 1'b0;
            presc_set_q <= 1'b0;
        end else begin
            if (accept[SEL_START]) begin
                start_q     <= bus_wdata;
                start_set_q <= 1'b1;
            end
            if (accept[SEL_PRESC]) begin
                presc_q     <= bus_wdata;
                presc_set_q <= 1'b1;
            end
        end
    end

    assign en_set = accept[SEL_EN] && bus_wdata[0] && start_set_q && presc_set_q && !en_q;
    assign kick   = accept[SEL_KICK] && bus_wdata == KICK_CODE && en_q;

    always_ff @(posedge clk) begin
        if (rst)
            en_q <= 1'b0;
        else if (en_set)
            en_q <= 1'b1;
    end

    wdk_core #(.W(DW), .PULSE_LEN(PULSE_LEN)) u_core (
        .clk     (clk),
        .rst     (rst),
        .en_i    (en_q),
        .load_i  (en_set),
        .kick_i  (kick),
        .start_i (start_q),
        .presc_i (presc_q),
        .count_o (count),
        .rst_n_o (wdt_rst_n)
    );

    always_comb begin
        bus_rdata = '0;
        if (dec.valid) begin
            if (!dec.is_data) begin
                bus_rdata[1:0] = guard_st[dec.sel];
            end else begin
                case (dec.sel)
                    SEL_KICK:  bus_rdata = count;
                    SEL_START: bus_rdata = start_q;
                    SEL_EN:    bus_rdata[0] = en_q;
                    default:   bus_rdata = presc_q;
                endcase
            end
        end
    end

    // R6: once running, the watchdog stays running
    assert_enable_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        en_q |=> en_q);

    // R5: starting requires both start value and prescale to have been set
    assert_enable_needs_config_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(en_q) |-> (start_set_q && presc_set_q));
endmodule

// File: tb/tb_wdog_keylock_top.sv
module tb_wdog_keylock_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        wdt_rst_n;

    int unsigned cyc = 0;
    int checks = 0;
    int failures = 0;

    wdog_keylock_top dut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdt_rst_n(wdt_rst_n)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [15:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [15:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic unlock(logic [3:0] guard_addr);
        wr(guard_addr, 16'h5555);
        wr(guard_addr, 16'hAAAA);
    endtask

    function automatic logic [15:0] exp_count(int sv, int ps, int k);
        return 16'(sv - k / (ps + 1));
    endfunction

    function automatic logic [1:0] model_next(logic [1:0] s, logic [15:0] v);
        if (v == 16'h5555) return 2'd1;
        if (v == 16'hAAAA && s == 2'd1) return 2'd2;
        return 2'd0;
    endfunction

    task automatic expect_expiry(int unsigned x, string req);
        while (cyc < x - 1) @(negedge clk);
        chk(req, {15'b0, wdt_rst_n}, 16'd1);
        @(negedge clk);
        chk(req, {15'b0, wdt_rst_n}, 16'd0);
    endtask

    initial begin
        #(5.0 * 150000);
        failures++;
        $display("FAIL watchdog got=hung expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [15:0] r;
        logic [1:0]  ls [2];
        logic [15:0] val [2];
        int unsigned ld, x, k;
        void'($urandom(32'd20161));

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R10: reset state
        chk("R10", {15'b0, wdt_rst_n}, 16'd1);
        for (int i = 0; i < 4; i++) begin
            rd(4'(i * 4), r); chk("R10", r, 16'd0);
        end
        rd(4'h6, r); chk("R10", r, 16'hFFFF);
        rd(4'hE, r); chk("R10", r, 16'h0000);
        rd(4'hA, r); chk("R10", r, 16'h0000);
        rd(4'h2, r); chk("R10", r, 16'h0000);
        @(negedge clk);

        // R3: a write without unlocking is ignored
        wr(4'h6, 16'h1234);
        rd(4'h6, r); chk("R3", r, 16'hFFFF);

        // R1: the two keys step the guard to open
        wr(4'h4, 16'h5555); rd(4'h4, r); chk("R1", r, 16'd1);
        wr(4'h4, 16'hAAAA); rd(4'h4, r); chk("R1", r, 16'd2);

        // R4: one write goes through, then the guard is closed
        wr(4'h6, 16'd3);
        rd(4'h6, r); chk("R4", r, 16'd3);
        rd(4'h4, r); chk("R4", r, 16'd0);
        wr(4'h6, 16'd9);
        rd(4'h6, r); chk("R4", r, 16'd3);

        // R2: wrong or out-of-order keys
        wr(4'h4, 16'h5555); wr(4'h4, 16'h1111);
        rd(4'h4, r); chk("R2", r, 16'd0);
        wr(4'h4, 16'hAAAA);
        rd(4'h4, r); chk("R2", r, 16'd0);
        wr(4'h4, 16'h5555); wr(4'h4, 16'h5555);
        rd(4'h4, r); chk("R2", r, 16'd1);
        wr(4'h4, 16'hAAAA); wr(4'h4, 16'h0000);
        rd(4'h4, r); chk("R2", r, 16'd0);

        // R11: odd address writes are ignored entirely
        unlock(4'h4);
        wr(4'h7, 16'd5);
        rd(4'h6, r); chk("R11", r, 16'd3);
        rd(4'h4, r); chk("R11", r, 16'd2);
        wr(4'h5, 16'h1234);
        rd(4'h4, r); chk("R11", r, 16'd2);
        wr(4'h6, 16'd3);

        // R5: enable refused while prescale never set
        unlock(4'h8);
        wr(4'hA, 16'd1);
        rd(4'hA, r); chk("R5", r, 16'd0);
        rd(4'h8, r); chk("R5", r, 16'd0);
        chk("R5", {15'b0, wdt_rst_n}, 16'd1);

        // R1 R2 R3 R4: random guard and data traffic on start and prescale
        rd(4'h6, r); val[0] = r;
        rd(4'hE, r); val[1] = r;
        ls[0] = 2'd0; ls[1] = 2'd0;
        for (int n = 0; n < 80; n++) begin
            int p, kind, kc;
            logic [15:0] v;
            logic [3:0] base;
            p = int'($urandom % 2);
            base = (p == 0) ? 4'h4 : 4'hC;
            kind = int'($urandom % 8);
            kc = int'($urandom % 3);
            v = (kc == 0) ? 16'h5555 : (kc == 1) ? 16'hAAAA : (16'($urandom) & 16'h0FF0);
            if (kind < 4) begin
                wr(base, v);
                ls[p] = model_next(ls[p], v);
            end else if (kind < 7) begin
                v = 16'($urandom);
                wr(base + 4'd2, v);
                if (ls[p] == 2'd2) begin val[p] = v; ls[p] = 2'd0; end
            end else begin
                wr(base + 4'd3, v);
            end
            rd(base, r); chk("R1", r, {14'b0, ls[p]});
            rd(base + 4'd2, r); chk("R3", r, val[p]);
        end

        // R5: enable after configuration
        unlock(4'h4); wr(4'h6, 16'd3);
        unlock(4'hC); wr(4'hE, 16'd1);
        unlock(4'h8); wr(4'hA, 16'd1);
        ld = cyc;
        rd(4'hA, r); chk("R5", r, 16'd1);
        rd(4'h2, r); chk("R5", r, 16'd3);

        // R7: expiry after (3+1)*(1+1) = 8 edges
        x = ld + 8;
        expect_expiry(x, "R7");

        // R8: reprogram start during the pulse; pulse length and reload
        unlock(4'h4); wr(4'h6, 16'd20);
        chk("R8", {15'b0, wdt_rst_n}, 16'd0);
        while (cyc < x + 15) @(negedge clk);
        chk("R8", {15'b0, wdt_rst_n}, 16'd0);
        @(negedge clk);
        chk("R8", {15'b0, wdt_rst_n}, 16'd1);
        rd(4'h2, r); chk("R8", r, 16'd20);
        ld = x + 16;

        // R6: an accepted enable write of 0 does not stop it
        unlock(4'h8); wr(4'hA, 16'd0);
        rd(4'hA, r); chk("R6", r, 16'd1);

        // R9: wrong kick code has no effect but closes the guard
        unlock(4'h0); wr(4'h2, 16'h1234);
        rd(4'h0, r); chk("R9", r, 16'd0);
        k = cyc - ld;
        rd(4'h2, r); chk("R9", r, exp_count(20, 1, int'(k)));

        // R9: correct kick reloads, next expiry 42 edges later
        unlock(4'h0); wr(4'h2, 16'hC0DE);
        ld = cyc;
        rd(4'h2, r); chk("R9", r, 16'd20);
        expect_expiry(ld + 42, "R9");

        // R6 R10: only reset stops it
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R6", {15'b0, wdt_rst_n}, 16'd1);
        rd(4'hA, r); chk("R6", r, 16'd0);
        rd(4'h2, r); chk("R10", r, 16'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule